// File: doc/BRIEF.md
# Multi-bank FIR filter

A direct-form finite impulse response filter with eight taps that keeps four coefficient sets in constant storage. Every input sample travels with a 2-bit bank index. That index picks the coefficient set that the sample's whole output is computed with, so the filter can change its response from one sample to the next. The same structure is repeated for a configurable number of parallel channels. Each channel has its own delay line, its own bank index and its own output. The channels share one input handshake and one output handshake.

Input and output are valid/ready streams. A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. A result is taken on a rising edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the whole pipeline freezes and `in_ready` drops. With `out_ready` held high the filter takes one word per cycle. The delay lines move only when a word is accepted, so idle cycles leave the filter state unchanged.

Top module: `fir_mb_top`

## Requirements
- R1: After reset, `out_valid` is low and every delay-line entry is zero. The first output after reset is therefore C(b,0)·x for a first sample x with bank b.
- R2: Channel n takes bits [10n+9:10n] of `in_data`. Within that field, bits [10n+9:10n+8] hold the unsigned bank index and bits [10n+7:10n] hold the sample as 8-bit two's complement.
- R3: For an accepted sample x[k] with bank b, channel n returns y = Σ C(b,t)·x[k−t] for t = 0..7. The sum is exact, with older samples taken from that channel's history. It appears as 22-bit two's complement on `out_sample` bits [22n+21:22n].
- R4: Coefficient t of bank b is C(b,t) = 16·(((37b + 113t + 5) mod 255) − 127) + b. Every coefficient lies in −2047..2047.
- R5: The bank index applies to its own sample only. A sequence whose bank changes on every sample yields, for each sample, the sum computed with that sample's bank.
- R6: Channels are independent. Holding each channel's bank at its channel number gives each channel its own response to its own samples.
- R7: With `out_ready` held high, a word accepted at clock edge k produces `out_valid` high after edge k+2. That is the third falling edge after the accepting edge.
- R8: Exactly one output is produced per accepted word. When `in_valid` is low, no output is produced and the delay lines do not move.
- R9: When `out_valid` is high and `out_ready` is low, `in_ready` is low. On the next cycle `out_valid` stays high and `out_sample` is unchanged. No result is lost or repeated.
- R10: `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R11: The accumulated sum always fits the 22-bit output without wrapping, including full-scale inputs of −128 and 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Filter can accept a word this cycle |
| in_data | input | 10·NUM_CH | Per channel: bank index and sample |
| out_valid | output | 1 | Output word valid, shared by all channels |
| out_ready | input | 1 | Downstream takes the output word |
| out_sample | output | 22·NUM_CH | Per channel filtered result |

## Verification
Impulse inputs held on one bank read back each coefficient of that bank in tap order. A wrong tap order or a wrong bank table shows up here, even where a plain sum would hide it. A stream whose bank index cycles on every sample separates per-sample bank selection from a bank that is latched too early or too late. Fixed bank-equals-channel traffic with different samples per lane exposes crossed channel fields. Random valid gaps and random back-pressure separate a delay line that shifts only on acceptance from one that shifts on every clock, and they also catch a stall that drops or repeats results. Full-scale runs of −128 and 127 probe the accumulator width.

// File: rtl/fir_mb_pkg.sv
package fir_mb_pkg;

  // Default geometry of one filter lane.
  localparam int SAMPLE_W_D = 8;
  localparam int BANK_W_D   = 2;
  localparam int COEF_W_D   = 12;
  localparam int OUT_W_D    = 22;
  localparam int TAPS_D     = 8;
  localparam int NUM_CH_D   = 4;

  // Coefficient generator: bank b, tap t. Magnitude stays below 2048.
  function automatic int coef_value(input int bank, input int tap);
    int r;
    r = (37 * bank + 113 * tap + 5) % 255;
    return 16 * (r - 127) + bank;
  endfunction

endpackage

// File: rtl/fir_mb_ctrl.sv
module fir_mb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic accept,
  output logic en,
  output logic out_valid
);

  // Stage flags: delay line holds a fresh sample, products hold one.
  logic v_line;
  logic v_prod;

  // A held result blocks every stage; otherwise the pipe moves.
  assign en       = !out_valid || out_ready;
  assign in_ready = en;
  assign accept   = in_valid && en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_line    <= 1'b0;
      v_prod    <= 1'b0;
      out_valid <= 1'b0;
    end else if (en) begin
      v_line    <= accept;
      v_prod    <= v_line;
      out_valid <= v_prod;
    end
  end

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable({v_line, v_prod, out_valid})); // R9

  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(v_prod)); // R8

endmodule

// File: rtl/fir_mb_delay.sv
module fir_mb_delay #(
  parameter int TAPS     = fir_mb_pkg::TAPS_D,
  parameter int SAMPLE_W = fir_mb_pkg::SAMPLE_W_D,
  parameter int BANK_W   = fir_mb_pkg::BANK_W_D
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift,
  input  logic [SAMPLE_W-1:0]        sample_in,
  input  logic [BANK_W-1:0]          bank_in,
  output logic [TAPS*SAMPLE_W-1:0]   taps_flat,
  output logic [BANK_W-1:0]          bank_q
);

  localparam int LINE_W = TAPS * SAMPLE_W;

  // Tap 0 is the newest sample, tap TAPS-1 the oldest.
  logic [LINE_W-1:0] taps_q;

  generate
    if (TAPS == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     taps_q <= '0;
        else if (shift) taps_q <= sample_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     taps_q <= '0;
        else if (shift) taps_q <= {taps_q[LINE_W-SAMPLE_W-1:0], sample_in};
      end
    end
  endgenerate

  // The bank travels with the sample it came with.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= '0;
    else if (shift) bank_q <= bank_in;
  end

  assign taps_flat = taps_q;

  AST_LINE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(taps_q)); // R8

endmodule

// File: rtl/fir_mb_coef_rom.sv
module fir_mb_coef_rom #(
  parameter int TAPS   = fir_mb_pkg::TAPS_D,
  parameter int BANK_W = fir_mb_pkg::BANK_W_D,
  parameter int COEF_W = fir_mb_pkg::COEF_W_D
) (
  input  logic [BANK_W-1:0]        bank,
  output logic [TAPS*COEF_W-1:0]   coef_flat
);

  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int ROW_W     = TAPS * COEF_W;

  logic [ROW_W-1:0] table_rows [NUM_BANKS];

  // Constant table computed from the generator function.
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int t = 0; t < TAPS; t++) begin
        table_rows[b][t*COEF_W +: COEF_W] = COEF_W'(fir_mb_pkg::coef_value(b, t));
      end
    end
  end

  assign coef_flat = table_rows[bank];

endmodule

// File: rtl/fir_mb_mac.sv
module fir_mb_mac #(
  parameter int TAPS     = fir_mb_pkg::TAPS_D,
  parameter int SAMPLE_W = fir_mb_pkg::SAMPLE_W_D,
  parameter int COEF_W   = fir_mb_pkg::COEF_W_D,
  parameter int OUT_W    = fir_mb_pkg::OUT_W_D
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [TAPS*SAMPLE_W-1:0]  taps_flat,
  input  logic [TAPS*COEF_W-1:0]    coef_flat,
  output logic [OUT_W-1:0]          sum_out
);

  localparam int PROD_W = SAMPLE_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(TAPS);

  logic signed [PROD_W-1:0] prod_q [TAPS];
  logic signed [ACC_W-1:0]  acc_d;
  logic signed [ACC_W-1:0]  sum_q;

  // Stage one: one registered multiplier per tap.
  generate
    for (genvar t = 0; t < TAPS; t++) begin : g_mul
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prod_q[t] <= '0;
        end else if (en) begin
          prod_q[t] <= PROD_W'($signed(taps_flat[t*SAMPLE_W +: SAMPLE_W]))
                     * PROD_W'($signed(coef_flat[t*COEF_W +: COEF_W]));
        end
      end
    end
  endgenerate

  // Stage two: full-precision sum of the products.
  always_comb begin
    acc_d = '0;
    for (int t = 0; t < TAPS; t++) begin
      acc_d = acc_d + ACC_W'(prod_q[t]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sum_q <= '0;
    else if (en) sum_q <= acc_d;
  end

  assign sum_out = OUT_W'(sum_q);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $signed(sum_out) == sum_q); // R11

endmodule

// File: rtl/fir_mb_top.sv
module fir_mb_top #(
  parameter int NUM_CH   = fir_mb_pkg::NUM_CH_D,
  parameter int TAPS     = fir_mb_pkg::TAPS_D,
  parameter int SAMPLE_W = fir_mb_pkg::SAMPLE_W_D,
  parameter int BANK_W   = fir_mb_pkg::BANK_W_D,
  parameter int COEF_W   = fir_mb_pkg::COEF_W_D,
  parameter int OUT_W    = fir_mb_pkg::OUT_W_D,
  localparam int FIELD_W = BANK_W + SAMPLE_W,
  localparam int IN_BUS  = NUM_CH * FIELD_W,
  localparam int OUT_BUS = NUM_CH * OUT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [IN_BUS-1:0]   in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OUT_BUS-1:0]  out_sample
);

  logic accept;
  logic en;

  fir_mb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .accept    (accept),
    .en        (en),
    .out_valid (out_valid)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
      logic [FIELD_W-1:0]        field;
      logic [TAPS*SAMPLE_W-1:0]  taps_flat;
      logic [TAPS*COEF_W-1:0]    coef_flat;
      logic [BANK_W-1:0]         bank_q;

      assign field = in_data[ch*FIELD_W +: FIELD_W];

      fir_mb_delay #(
        .TAPS(TAPS), .SAMPLE_W(SAMPLE_W), .BANK_W(BANK_W)
      ) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift     (accept),
        .sample_in (field[SAMPLE_W-1:0]),
        .bank_in   (field[FIELD_W-1:SAMPLE_W]),
        .taps_flat (taps_flat),
        .bank_q    (bank_q)
      );

      fir_mb_coef_rom #(
        .TAPS(TAPS), .BANK_W(BANK_W), .COEF_W(COEF_W)
      ) u_rom (
        .bank      (bank_q),
        .coef_flat (coef_flat)
      );

      fir_mb_mac #(
        .TAPS(TAPS), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .OUT_W(OUT_W)
      ) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .taps_flat (taps_flat),
        .coef_flat (coef_flat),
        .sum_out   (out_sample[ch*OUT_W +: OUT_W])
      );
    end
  endgenerate

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample))); // R9

  AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R10

endmodule

// File: tb/fir_mb_top_tb_top.sv
module fir_mb_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH  = 4;
  localparam int TAPS    = 8;
  localparam int FIELD_W = 10;
  localparam int OUT_W   = 22;
  localparam int IN_BUS  = NUM_CH * FIELD_W;
  localparam int OUT_BUS = NUM_CH * OUT_W;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [IN_BUS-1:0]  in_data = '0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [OUT_BUS-1:0] out_sample;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  string cur_req = "R3";

  int hist [NUM_CH][TAPS];
  logic [OUT_BUS-1:0] exp_q [$];
  bit stall_prev = 1'b0;
  logic [OUT_BUS-1:0] stall_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_mb_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
  );

  function automatic int exp_coef(input int b, input int t);
    return 16 * (((37 * b + 113 * t + 5) % 255) - 127) + b;
  endfunction

  function automatic logic [FIELD_W-1:0] fld(input int b, input int s);
    logic [1:0] bb;
    logic [7:0] ss;
    bb = 2'(b);
    ss = 8'(s);
    return {bb, ss};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic model_push(input logic [IN_BUS-1:0] d);
    logic [OUT_BUS-1:0] e;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      int b;
      int s;
      int y;
      b = int'(d[ch*FIELD_W + 8 +: 2]);
      s = $signed(d[ch*FIELD_W +: 8]);
      for (int t = TAPS - 1; t > 0; t--) hist[ch][t] = hist[ch][t-1];
      hist[ch][0] = s;
      y = 0;
      for (int t = 0; t < TAPS; t++) y += exp_coef(b, t) * hist[ch][t];
      e[ch*OUT_W +: OUT_W] = OUT_W'(y);
    end
    exp_q.push_back(e);
  endtask

  task automatic step(input bit iv, input logic [IN_BUS-1:0] d, input bit ordy);
    @(negedge clk);
    if (stall_prev) begin
      check(out_valid === 1'b1 && out_sample === stall_val, "R9 held output",
            {out_valid, out_sample}, {1'b1, stall_val});
    end
    in_valid  = iv;
    in_data   = d;
    out_ready = ordy;
    #1;
    if (out_valid && !out_ready) begin
      check(in_ready === 1'b0, "R9 ready low while stalled", in_ready, 0);
    end else begin
      check(in_ready === 1'b1, "R10 ready when free", in_ready, 1);
    end
    stall_prev = out_valid && !out_ready;
    stall_val  = out_sample;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected output", out_sample, 0);
      end else begin
        logic [OUT_BUS-1:0] e;
        e = exp_q.pop_front();
        check(out_sample === e, cur_req, out_sample, e);
      end
    end
    if (in_valid && in_ready) model_push(d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b1;
    stall_prev = 1'b0;
    exp_q.delete();
    for (int c = 0; c < NUM_CH; c++)
      for (int t = 0; t < TAPS; t++) hist[c][t] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) step(1'b0, '0, 1'b1);
    check(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [IN_BUS-1:0] w;
    int first;
    void'($urandom(32'd20240611));

    do_reset();
    @(negedge clk); #1;
    check(out_valid === 1'b0, "R1 out_valid low after reset", out_valid, 0);
    check(in_ready === 1'b1, "R10 ready after reset", in_ready, 1);

    // Latency and first result after reset: x=5 on bank 2, all lanes.
    cur_req = "R1 first output";
    w = '0;
    for (int c = 0; c < NUM_CH; c++) w[c*FIELD_W +: FIELD_W] = fld(2, 5);
    step(1'b1, w, 1'b1);
    first = 0;
    for (int k = 1; k <= 5; k++) begin
      step(1'b0, '0, 1'b1);
      if (out_valid && first == 0) first = k;
    end
    check(first == 3, "R7 latency in cycles", first, 3);
    drain();

    // Idle: no output, no movement (R8).
    for (int k = 0; k < 10; k++) begin
      step(1'b0, '0, 1'b1);
      check(out_valid === 1'b0, "R8 no output while idle", out_valid, 0);
    end

    // Impulse responses per bank (R4), lane c uses bank (b+c)%4.
    for (int b = 0; b < 4; b++) begin
      do_reset();
      cur_req = "R4 impulse coefficient";
      for (int k = 0; k < TAPS; k++) begin
        w = '0;
        for (int c = 0; c < NUM_CH; c++) w[c*FIELD_W +: FIELD_W] = fld((b + c) % 4, k == 0 ? 1 : 0);
        step(1'b1, w, 1'b1);
      end
      drain();
    end

    // Bank cycling every sample (R5).
    cur_req = "R5 per-sample bank";
    for (int k = 0; k < 40; k++) begin
      w = '0;
      for (int c = 0; c < NUM_CH; c++) w[c*FIELD_W +: FIELD_W] = fld(k % 4, int'($urandom_range(255)) - 128);
      step(1'b1, w, 1'b1);
    end
    drain();

    // Bank fixed to lane number (R6).
    cur_req = "R6 lane independence";
    for (int k = 0; k < 40; k++) begin
      w = '0;
      for (int c = 0; c < NUM_CH; c++) w[c*FIELD_W +: FIELD_W] = fld(c, int'($urandom_range(255)) - 128);
      step(1'b1, w, 1'b1);
    end
    drain();

    // Random fields per lane (R2/R3).
    cur_req = "R2 R3 field packing and sum";
    for (int k = 0; k < 200; k++) begin
      w = IN_BUS'({$urandom(), $urandom()});
      step(1'b1, w, 1'b1);
    end
    drain();

    // Full-scale runs (R11).
    cur_req = "R11 full scale";
    for (int k = 0; k < 48; k++) begin
      w = '0;
      for (int c = 0; c < NUM_CH; c++)
        w[c*FIELD_W +: FIELD_W] = fld((k / 12 + c) % 4, ((k / 8) % 2 == 0) ? -128 : 127);
      step(1'b1, w, 1'b1);
    end
    drain();

    // Random valid gaps and back-pressure (R8/R9).
    cur_req = "R9 R8 gaps and stalls";
    for (int k = 0; k < 3000; k++) begin
      w = IN_BUS'({$urandom(), $urandom()});
      step($urandom_range(3) != 0, w, $urandom_range(2) != 0);
    end
    drain();

    finish_run();
  end

endmodule